// File: doc/BRIEF.md
# DS3 Nibble-Parallel Transmit Payload Interface

This block sits between terminal equipment and a DS3 transmit framer. It runs on the transmit line clock and derives a gapped nibble clock from it. The nibble clock is the line clock divided by four, and it is suppressed for every bit slot that the framer reserves for overhead. As a result, only payload nibbles are requested, exactly 1176 of them per frame. The terminal equipment presents each nibble on the 4-bit bus from the rising edge of the nibble clock. The block captures the nibble on the third line-clock rising edge after that nibble-clock edge and hands it on with a one-cycle valid strobe.

The frame is counted as 4760 line-clock bit slots. These form 56 blocks of 85 slots each, and the first slot of every block is overhead. In frame-slave mode, the rising edge of an external frame reference realigns the frame so that the reference cycle is the first payload slot. A reference edge that lands away from the expected boundary also raises a one-cycle alignment error. In frame-master mode, the reference is ignored and the block paces the frame itself. In both modes a frame-start pulse spans the first payload nibble of the frame.

Top module: `ds3_nib_tx_if`

## Requirements
- R1: While running, `nib_clk` is high for two line cycles and low for two line cycles in each payload nibble period. It is low for the single overhead slot (slot 0) of every 85-slot block. A block holds 21 nibble periods in slots 1 to 84.
- R2: Between two consecutive rising edges of `frame_start` there are exactly 4760 line cycles and exactly 1176 rising edges of `nib_clk`, counting the one that coincides with the later `frame_start` edge into the next frame.
- R3: `nib_in` is captured on the third line-clock rising edge after the edge that raised `nib_clk`. In the cycle that follows, `nib_out` shows the captured value and `nib_valid` is high for that one cycle only. At other times `nib_out` holds its value.
- R4: In frame-slave mode (`mode_master`=0), a rising edge of `frame_ref` seen at a clock edge marks the cycle before that edge as slot 1 of block 0. Counting then continues from slot 2, so `frame_start` is high in the cycle after the edge.
- R5: `frame_start` is high during slots 1 to 4 of block 0, which is the first payload nibble period of each frame.
- R6: `align_err` pulses high for one cycle after a frame-slave reference edge that does not fall on slot 1 of block 0. It stays low for an aligned edge and for the first edge after reset.
- R7: In frame-master mode (`mode_master`=1), `frame_ref` has no effect: there is no realignment and no `align_err`. After reset, the first frame starts in the first counting cycle.
- R8: `rst_n` is asserted asynchronously and active low, and takes effect two line-clock edges after it is released. Reset clears `nib_out`, `nib_valid`, `frame_start`, `align_err` and `nib_clk`. `nib_clk` and `frame_start` then stay low until the first frame start: the first reference edge in slave mode, or the first counting cycle in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit line clock, one bit slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = frame-master, 0 = frame-slave |
| frame_ref | input | 1 | External frame reference pulse |
| nib_in | input | 4 | Payload nibble from terminal equipment |
| nib_clk | output | 1 | Gapped divide-by-four nibble clock |
| frame_start | output | 1 | First-payload-nibble frame marker |
| nib_out | output | 4 | Captured nibble |
| nib_valid | output | 1 | One-cycle strobe for a new `nib_out` |
| align_err | output | 1 | Misaligned reference indication |

## Verification
The master-mode run covers more than two full frames while `frame_ref` toggles with an unrelated period. This separates correct gapping and the 1176-nibble count from reference leakage into the counters. The slave-mode run first idles without a reference to show that the nibble clock stays silent. It then applies a first edge and an exactly aligned edge, which must realign without error. Finally it applies an edge away from the boundary, which must both resync and flag. The nibble bus carries a changing value every cycle, so capturing one edge early or late shows up as a data mismatch.

// File: rtl/ds3nib_pkg.sv
package ds3nib_pkg;

  parameter int unsigned DEF_SLOTS = 85;   // bit slots per block, slot 0 is overhead
  parameter int unsigned DEF_BLKS  = 56;   // blocks per frame
  parameter int unsigned DEF_NW    = 4;    // nibble width = line clocks per nibble

  typedef struct packed {
    logic nclk;
    logic fstart;
    logic capture;
    logic err;
  } tbase_o_t;

endpackage

// File: rtl/ds3nib_rst_sync.sv
module ds3nib_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/ds3nib_timebase.sv
module ds3nib_timebase
  import ds3nib_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned BLKS  = DEF_BLKS,
  parameter int unsigned NW    = DEF_NW
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_master,
  input  logic     frame_ref,
  output tbase_o_t tb_o
);
  localparam int unsigned POS_W  = $clog2(SLOTS);
  localparam int unsigned BLK_W  = $clog2(BLKS);
  localparam int unsigned PH_W   = $clog2(NW);
  localparam int unsigned HIGH_N = NW / 2;   // nibble clock high phases
  localparam int unsigned CAP_PH = 2;        // third line edge after rise

  logic [POS_W-1:0] pos_q, pos_n;
  logic [BLK_W-1:0] blk_q, blk_n;
  logic [PH_W-1:0]  ph_q,  ph_n;
  logic             run_q, run_n;
  logic             refd_q;
  logic             err_q, err_n;
  logic             ref_rise;
  logic             at_boundary;
  logic             last_slot;

  assign ref_rise    = !mode_master && frame_ref && !refd_q;
  assign at_boundary = (blk_q == '0) && (pos_q == POS_W'(1));
  assign last_slot   = (pos_q == POS_W'(SLOTS - 1));

  // next-state
  always_comb begin
    pos_n = pos_q;
    blk_n = blk_q;
    ph_n  = ph_q;
    run_n = run_q;
    err_n = ref_rise && run_q && !at_boundary;
    if (ref_rise) begin
      pos_n = POS_W'(2);
      blk_n = '0;
      ph_n  = PH_W'(1);
      run_n = 1'b1;
    end else begin
      if (last_slot) begin
        pos_n = '0;
        ph_n  = '0;
        blk_n = (blk_q == BLK_W'(BLKS - 1)) ? '0 : blk_q + 1'b1;
      end else begin
        pos_n = pos_q + 1'b1;
        if (pos_q == '0) begin
          ph_n = '0;
        end else begin
          ph_n = (ph_q == PH_W'(NW - 1)) ? '0 : ph_q + 1'b1;
        end
      end
      if (mode_master && (pos_n == POS_W'(1)) && (blk_n == '0)) begin
        run_n = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      blk_q  <= '0;
      ph_q   <= '0;
      run_q  <= 1'b0;
      refd_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      blk_q  <= blk_n;
      ph_q   <= ph_n;
      run_q  <= run_n;
      refd_q <= frame_ref;
      err_q  <= err_n;
    end
  end

  // output decode
  always_comb begin
    tb_o.nclk    = run_q && (pos_q != '0) && (ph_q < PH_W'(HIGH_N));
    tb_o.capture = run_q && (pos_q != '0) && (ph_q == PH_W'(CAP_PH));
    tb_o.fstart  = run_q && (blk_q == '0) && (pos_q != '0) &&
                   (pos_q <= POS_W'(NW));
    tb_o.err     = err_q;
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q < POS_W'(SLOTS)) && (blk_q < BLK_W'(BLKS))); // R2

  AST_NCLK_TWO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && $rose(tb_o.nclk)) |=> tb_o.nclk); // R1

  AST_FS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && $rose(tb_o.fstart)) |=> tb_o.fstart); // R5

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tb_o.err |=> !tb_o.err); // R6

  AST_MASTER_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && $past(mode_master)) |-> !tb_o.err); // R7

endmodule

// File: rtl/ds3nib_capture.sv
module ds3nib_capture #(
  parameter int unsigned NW = ds3nib_pkg::DEF_NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [NW-1:0] nib_in,
  output logic [NW-1:0] nib_out,
  output logic          nib_valid
);
  logic [NW-1:0] dat_q, dat_n;
  logic          vld_q, vld_n;

  always_comb begin
    dat_n = capture ? nib_in : dat_q;
    vld_n = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dat_q <= dat_n;
      vld_q <= vld_n;
    end
  end

  assign nib_out   = dat_q;
  assign nib_valid = vld_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_valid |-> $stable(nib_out) || $past(!rst_n)); // R3

endmodule

// File: rtl/ds3_nib_tx_if.sv
module ds3_nib_tx_if
  import ds3nib_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned BLKS  = DEF_BLKS,
  parameter int unsigned NW    = DEF_NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_master,
  input  logic          frame_ref,
  input  logic [NW-1:0] nib_in,
  output logic          nib_clk,
  output logic          frame_start,
  output logic [NW-1:0] nib_out,
  output logic          nib_valid,
  output logic          align_err
);
  logic     rst_i_n;
  tbase_o_t tbo;

  ds3nib_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ds3nib_timebase #(.SLOTS(SLOTS), .BLKS(BLKS), .NW(NW)) u_tbase (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .mode_master (mode_master),
    .frame_ref   (frame_ref),
    .tb_o        (tbo)
  );

  ds3nib_capture #(.NW(NW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .capture   (tbo.capture),
    .nib_in    (nib_in),
    .nib_out   (nib_out),
    .nib_valid (nib_valid)
  );

  assign nib_clk     = tbo.nclk;
  assign frame_start = tbo.fstart;
  assign align_err   = tbo.err;

  AST_VALID_AFTER_NCLK: assert property (@(posedge clk) disable iff (!rst_i_n)
    nib_valid |-> (!$past(nib_clk) && $past(nib_clk, 2))); // R3

  AST_SLAVE_REALIGN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!mode_master && $past(!mode_master) && $past($rose(frame_ref))) |->
      frame_start); // R4

endmodule

// File: tb/sim_ds3_nib_tx_if.sv
module sim_ds3_nib_tx_if;
  localparam int SLOTS = 85;
  localparam int BLKS  = 56;
  localparam int FRAME = SLOTS * BLKS;

  logic       clk = 1'b0;
  logic       rst_n, mode_master, frame_ref;
  logic [3:0] nib_in;
  logic       nib_clk, frame_start, nib_valid, align_err;
  logic [3:0] nib_out;

  always #10 clk = ~clk;

  ds3_nib_tx_if u0 (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .frame_ref(frame_ref),
    .nib_in(nib_in), .nib_clk(nib_clk), .frame_start(frame_start),
    .nib_out(nib_out), .nib_valid(nib_valid), .align_err(align_err)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pos, m_blk, m_run, m_refd, m_err, m_vld, m_nib, m_rc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rc = 0; m_pos = 0; m_blk = 0; m_run = 0; m_refd = 0;
      m_err = 0; m_vld = 0; m_nib = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      bit rise, cap;
      rise = !mode_master && frame_ref && !m_refd;
      cap  = m_run && m_pos != 0 && ((m_pos - 1) % 4) == 2;
      m_vld = cap;
      if (cap) m_nib = nib_in;
      m_err = rise && m_run && !(m_blk == 0 && m_pos == 1);
      if (rise) begin
        m_pos = 2; m_blk = 0; m_run = 1;
      end else begin
        m_pos++;
        if (m_pos == SLOTS) begin
          m_pos = 0;
          m_blk = (m_blk + 1) % BLKS;
        end
        if (mode_master && m_pos == 1 && m_blk == 0) m_run = 1;
      end
      m_refd = frame_ref;
    end
  end

  // per-cycle comparison, away from the active edge
  bit p_nclk, p_fs, seen_fs, r2_en;
  int nclk_cnt, cyc_cnt, err_seen;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      int e_nclk, e_fs;
      e_nclk = m_run && m_pos != 0 && ((m_pos - 1) % 4) < 2;
      e_fs   = m_run && m_blk == 0 && m_pos >= 1 && m_pos <= 4;
      chk("R1 nib_clk", nib_clk, e_nclk);
      chk("R5 frame_start", frame_start, e_fs);
      chk("R3 nib_valid", nib_valid, m_vld);
      chk("R3 nib_out", nib_out, m_nib);
      chk("R6 align_err", align_err, m_err);
      if (align_err) err_seen++;
      if (r2_en) begin
        cyc_cnt++;
        if (frame_start && !p_fs) begin
          if (seen_fs) begin
            chk("R2 nib_clk edges per frame", nclk_cnt, 1176);
            chk("R2 line cycles per frame", cyc_cnt, FRAME);
          end
          seen_fs = 1; nclk_cnt = 0; cyc_cnt = 0;
        end
        if (nib_clk && !p_nclk) nclk_cnt++;
      end
      p_nclk = nib_clk;
      p_fs   = frame_start;
    end
  end

  // drive the nibble bus with a changing value every cycle
  always @(negedge clk) nib_in <= nib_in + 4'd3;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; mode_master = 1; frame_ref = 0; nib_in = 4'd0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset nib_clk", nib_clk, 0);
    chk("R8 reset frame_start", frame_start, 0);
    chk("R8 reset nib_valid", nib_valid, 0);
    chk("R8 reset align_err", align_err, 0);
    chk("R8 reset nib_out", nib_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R8 still held after two edges", frame_start, 0);
    @(negedge clk);
    chk("R7 master first frame starts", frame_start, 1);
    // master mode, reference toggling, R2 windows measured
    r2_en = 1;
    for (int i = 0; i < 2 * FRAME + 300; i++) begin
      frame_ref = ((i % 37) < 5);
      @(negedge clk);
    end
    r2_en = 0;
    chk("R7 no align_err in master", err_seen, 0);

    // slave mode
    rst_n = 0; mode_master = 0; frame_ref = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    begin
      int nc = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (nib_clk || frame_start) nc++;
      end
      chk("R8 slave idle before reference", nc, 0);
    end
    frame_ref = 1;
    @(negedge clk);
    chk("R4 frame_start after first edge", frame_start, 1);
    repeat (3) @(negedge clk);
    frame_ref = 0;
    repeat (FRAME - 4) @(negedge clk);
    frame_ref = 1;                      // exactly aligned edge
    @(negedge clk);
    chk("R6 aligned edge no error", align_err, 0);
    chk("R6 no error from first edge", err_seen, 0);
    repeat (3) @(negedge clk);
    frame_ref = 0;
    repeat (1000) @(negedge clk);
    frame_ref = 1;                      // misaligned edge
    @(negedge clk);
    chk("R6 misaligned edge flags", align_err, 1);
    chk("R4 resync frame_start", frame_start, 1);
    @(negedge clk);
    chk("R6 error is one cycle", align_err, 0);
    repeat (2) @(negedge clk);
    frame_ref = 0;
    repeat (FRAME + 100) @(negedge clk);
    chk("R6 single error in slave run", err_seen, 1);
    summary();
  end
endmodule